// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block starts one memory-card command at a time and records what the card answers. Software programs a 32-bit argument and a 13-bit command control word over a simple register port. Writing the control word with its start bit set, while no command is in flight, hands the command index and argument to a card-side engine for exactly one cycle. The block then either completes at once (no answer expected) or collects response bytes until the card side signals the end of the answer.

Collected bytes land in four 32-bit response words, the first byte in the most significant position. When the answer ends, the block compares the number of bytes against the minimum for the selected response kind: four bytes for a short answer, sixteen for a long one. Enough bytes mark the response as finished; too few mark a timeout and wipe the response words. A status word copies the command index and holds three sticky event flags, each cleared by writing a one, and a level interrupt is the OR of the flags that software has enabled.

Top module: `cmdrsp_top`

## Requirements
- R1: After reset every readable register reads zero, `irq` is low and `card_cmd_valid` is low.
- R2: A write to address 1 keeps bits [12:0] only. If bit 8 is set and no command is in flight, `card_cmd_valid` is high for exactly the next cycle, with `card_cmd_index` equal to bits [5:0] and `card_cmd_arg` equal to the argument register (address 0).
- R3: On a launch, status bits [5:0] take the command index, status bits [8:6] clear, all response words clear, and status bit 11 (command sent) is set one cycle after `card_cmd_valid`.
- R4: With control bit 9 clear, the command finishes right after it is sent: response words stay zero and neither status bit 9 nor bit 10 changes.
- R5: Response byte i (counting from 0) is stored in response word i/4 (address 4 + i/4) at bits [8*(3 - i mod 4) +: 8]; bytes after the sixteenth are dropped.
- R6: With bit 9 set and bit 10 clear (short answer), at `card_rsp_done` a count of at least 4 bytes sets status bit 9; fewer sets status bit 10 and clears all response words.
- R7: With bits 9 and 10 set (long answer), at `card_rsp_done` a count of 16 sets status bit 9; fewer sets status bit 10 and clears all response words.
- R8: A write to address 2 clears exactly the status bits set in both the written value and 0xE00; the index field is untouched, and an event raised in the same cycle stays set.
- R9: `irq` equals (status[11] AND mask[0]) OR (status[9] AND mask[1]) OR (status[10] AND mask[2]).
- R10: While a command is in flight, writes to addresses 0 and 1 are ignored and no second command is started.
- R11: `card_rsp_valid` and `card_rsp_done` have no effect unless the block is waiting for an answer.
- R12: Reads are combinational by `reg_addr`: 0 argument, 1 control (zero-extended), 2 status (12 bits), 3 interrupt mask (3 bits, written from bits [2:0]), 4 to 7 response words 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| card_cmd_valid | output | 1 | One-cycle command hand-off to the card engine |
| card_cmd_index | output | 6 | Command index |
| card_cmd_arg | output | 32 | Command argument |
| card_rsp_valid | input | 1 | One response byte is present |
| card_rsp_byte | input | 8 | Response byte |
| card_rsp_done | input | 1 | End of the answer from the card engine |
| irq | output | 1 | Level interrupt from enabled status events |

## Verification
A register write takes effect at the next rising edge, so `card_cmd_valid` appears in the cycle after the launching write and the command-sent flag one cycle after that. A response byte shows in its word in the cycle after its strobe, and the finish or timeout flag, the cleared words and `irq` all move in the cycle after `card_rsp_done`. The bench applies inputs on the falling edge and keeps a behavioural model that advances on each rising edge, then compares strobe, index, argument, interrupt and the addressed read-back 1 ns after every falling edge, so each result is sampled in the cycle it is due.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

    localparam int WORD_W      = 32;
    localparam int CTRL_W      = 13;
    localparam int STAT_W      = 12;
    localparam int MASK_W      = 3;
    localparam int IDX_W       = 6;
    localparam int RSP_WORDS   = 4;
    localparam int BYTES_PER_W = WORD_W / 8;
    localparam int RSP_BYTES   = RSP_WORDS * BYTES_PER_W;
    localparam int ADDR_W      = 3;

    // control word bit positions
    localparam int CTL_START = 8;
    localparam int CTL_WAIT  = 9;
    localparam int CTL_LONG  = 10;

    // status word bit positions
    localparam int ST_RSPEND = 9;
    localparam int ST_TOUT   = 10;
    localparam int ST_SENT   = 11;
    localparam logic [STAT_W-1:0] ST_W1C_MASK = 12'hE00;

    // interrupt mask bit positions
    localparam int MK_SENT   = 0;
    localparam int MK_RSPEND = 1;
    localparam int MK_TOUT   = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_ARG   = 3'd0,
        A_CTRL  = 3'd1,
        A_STAT  = 3'd2,
        A_MASK  = 3'd3,
        A_RESP0 = 3'd4,
        A_RESP1 = 3'd5,
        A_RESP2 = 3'd6,
        A_RESP3 = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SEND = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/cmdrsp_seq.sv
module cmdrsp_seq
    import cmdrsp_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    parameter int SHORT_MIN = 4,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int BIDX_W   = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              want_rsp,
    input  logic              long_rsp,
    input  logic              rsp_valid,
    input  logic              rsp_done,
    output logic              cmd_valid,
    output logic              busy,
    output logic              sent_evt,
    output logic              finish_evt,
    output logic              tout_evt,
    output logic              byte_we,
    output logic [BIDX_W-1:0] byte_idx
);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             want;
        logic             lng;
    } seq_t;

    seq_t seq_d, seq_q;
    logic enough;

    always_comb begin
        seq_d      = seq_q;
        cmd_valid  = 1'b0;
        sent_evt   = 1'b0;
        finish_evt = 1'b0;
        tout_evt   = 1'b0;
        byte_we    = 1'b0;
        byte_idx   = seq_q.cnt[BIDX_W-1:0];
        enough     = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (launch) begin
                    seq_d.st   = SEQ_SEND;
                    seq_d.want = want_rsp;
                    seq_d.lng  = long_rsp;
                    seq_d.cnt  = '0;
                end
            end
            SEQ_SEND: begin
                cmd_valid = 1'b1;
                sent_evt  = 1'b1;
                seq_d.st  = seq_q.want ? SEQ_WAIT : SEQ_IDLE;
            end
            SEQ_WAIT: begin
                if (rsp_valid && (seq_q.cnt < CNT_W'(MAX_BYTES))) begin
                    byte_we   = 1'b1;
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
                if (rsp_done) begin
                    enough   = seq_q.lng ? (seq_d.cnt >= CNT_W'(MAX_BYTES))
                                         : (seq_d.cnt >= CNT_W'(SHORT_MIN));
                    finish_evt = enough;
                    tout_evt   = !enough;
                    seq_d.st   = SEQ_IDLE;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, cnt: '0, want: 1'b0, lng: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy = (seq_q.st != SEQ_IDLE);

endmodule

// File: rtl/cmdrsp_pack.sv
module cmdrsp_pack
    import cmdrsp_pkg::*;
#(
    parameter int NWORDS  = 4,
    localparam int NBYTES = NWORDS * BYTES_PER_W,
    localparam int BIDX_W = $clog2(NBYTES),
    localparam int LANE_W = $clog2(BYTES_PER_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     byte_we,
    input  logic [BIDX_W-1:0]        byte_idx,
    input  logic [7:0]               byte_data,
    output logic [NWORDS*WORD_W-1:0] words
);

    logic [LANE_W-1:0]        lane;
    logic [BIDX_W-LANE_W-1:0] wsel;
    int                       shift;

    assign lane  = byte_idx[LANE_W-1:0];
    assign wsel  = byte_idx[BIDX_W-1:LANE_W];
    // first byte of a word goes to the top lane
    assign shift = 8 * (BYTES_PER_W - 1 - int'(lane));

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (clear) begin
                word_d = '0;
            end else if (byte_we && (int'(wsel) == g)) begin
                word_d[shift +: 8] = byte_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign words[g*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/cmdrsp_top.sv
module cmdrsp_top
    import cmdrsp_pkg::*;
#(
    parameter int SHORT_MIN_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        card_cmd_valid,
    output logic [5:0]  card_cmd_index,
    output logic [31:0] card_cmd_arg,
    input  logic        card_rsp_valid,
    input  logic [7:0]  card_rsp_byte,
    input  logic        card_rsp_done,
    output logic        irq
);

    localparam int BIDX_W = $clog2(RSP_BYTES);

    typedef struct packed {
        logic [WORD_W-1:0] arg;
        logic [CTRL_W-1:0] ctrl;
        logic [STAT_W-1:0] stat;
        logic [MASK_W-1:0] mask;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                        seq_busy;
    logic                        launch;
    logic                        sent_evt, finish_evt, tout_evt;
    logic                        byte_we;
    logic [BIDX_W-1:0]           byte_idx;
    logic [RSP_WORDS*WORD_W-1:0] rsp_words;
    logic                        wr_arg, wr_ctrl, wr_stat, wr_mask;

    assign wr_arg  = reg_wr && (reg_addr == A_ARG);
    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign wr_mask = reg_wr && (reg_addr == A_MASK);
    assign launch  = wr_ctrl && reg_wdata[CTL_START] && !seq_busy;

    cmdrsp_seq #(
        .MAX_BYTES (RSP_BYTES),
        .SHORT_MIN (SHORT_MIN_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .want_rsp   (reg_wdata[CTL_WAIT]),
        .long_rsp   (reg_wdata[CTL_LONG]),
        .rsp_valid  (card_rsp_valid),
        .rsp_done   (card_rsp_done),
        .cmd_valid  (card_cmd_valid),
        .busy       (seq_busy),
        .sent_evt   (sent_evt),
        .finish_evt (finish_evt),
        .tout_evt   (tout_evt),
        .byte_we    (byte_we),
        .byte_idx   (byte_idx)
    );

    cmdrsp_pack #(
        .NWORDS (RSP_WORDS)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch || tout_evt),
        .byte_we   (byte_we),
        .byte_idx  (byte_idx),
        .byte_data (card_rsp_byte),
        .words     (rsp_words)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_arg && !seq_busy) begin
            regs_d.arg = reg_wdata;
        end
        if (wr_ctrl && !seq_busy) begin
            regs_d.ctrl = reg_wdata[CTRL_W-1:0];
        end
        if (wr_mask) begin
            regs_d.mask = reg_wdata[MASK_W-1:0];
        end
        // software clear first, so an event in the same cycle survives
        if (wr_stat) begin
            regs_d.stat = regs_q.stat & ~(reg_wdata[STAT_W-1:0] & ST_W1C_MASK);
        end
        if (launch) begin
            regs_d.stat[8:0]       = '0;
            regs_d.stat[IDX_W-1:0] = reg_wdata[IDX_W-1:0];
        end
        if (sent_evt) begin
            regs_d.stat[ST_SENT] = 1'b1;
        end
        if (finish_evt) begin
            regs_d.stat[ST_RSPEND] = 1'b1;
        end
        if (tout_evt) begin
            regs_d.stat[ST_TOUT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_ARG:   reg_rdata = regs_q.arg;
            A_CTRL:  reg_rdata = WORD_W'(regs_q.ctrl);
            A_STAT:  reg_rdata = WORD_W'(regs_q.stat);
            A_MASK:  reg_rdata = WORD_W'(regs_q.mask);
            default: reg_rdata = rsp_words[(int'(reg_addr) - int'(A_RESP0)) * WORD_W +: WORD_W];
        endcase
    end

    assign card_cmd_index = regs_q.ctrl[IDX_W-1:0];
    assign card_cmd_arg   = regs_q.arg;

    assign irq = (regs_q.stat[ST_SENT]   && regs_q.mask[MK_SENT])
              || (regs_q.stat[ST_RSPEND] && regs_q.mask[MK_RSPEND])
              || (regs_q.stat[ST_TOUT]   && regs_q.mask[MK_TOUT]);

endmodule

// File: rtl/cmdrsp_chk.sv
module cmdrsp_chk
    import cmdrsp_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_wr,
    input logic [2:0]                  reg_addr,
    input logic [31:0]                 reg_wdata,
    input logic                        card_cmd_valid,
    input logic [5:0]                  card_cmd_index,
    input logic                        card_rsp_done,
    input logic                        irq,
    input logic                        busy,
    input logic [STAT_W-1:0]           stat,
    input logic [MASK_W-1:0]           mask,
    input logic [RSP_WORDS*WORD_W-1:0] resp
);

    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        card_cmd_valid |=> !card_cmd_valid);

    assert_sent_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        card_cmd_valid |=> stat[ST_SENT]);

    assert_launch_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (stat[5:0] == card_cmd_index) && (resp == '0));

    assert_tout_wipes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_TOUT]) |-> (resp == '0));

    assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(stat[ST_TOUT]) && $rose(stat[ST_RSPEND])));

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2 && reg_wdata[ST_RSPEND] && !card_rsp_done)
        |=> !stat[ST_RSPEND]);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat[ST_SENT] || stat[ST_RSPEND] || stat[ST_TOUT]));

    assert_no_reissue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !card_cmd_valid) |=> !card_cmd_valid);

endmodule

bind cmdrsp_top cmdrsp_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .card_cmd_valid (card_cmd_valid),
    .card_cmd_index (card_cmd_index),
    .card_rsp_done  (card_rsp_done),
    .irq            (irq),
    .busy           (seq_busy),
    .stat           (regs_q.stat),
    .mask           (regs_q.mask),
    .resp           (rsp_words)
);

// File: tb/tb_cmdrsp_top.sv
`timescale 1ns/1ps
module tb_cmdrsp_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        card_cmd_valid;
    logic [5:0]  card_cmd_index;
    logic [31:0] card_cmd_arg;
    logic        card_rsp_valid;
    logic [7:0]  card_rsp_byte;
    logic        card_rsp_done;
    logic        irq;

    always #2 clk = ~clk;

    cmdrsp_top dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_wr         (reg_wr),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .card_cmd_valid (card_cmd_valid),
        .card_cmd_index (card_cmd_index),
        .card_cmd_arg   (card_cmd_arg),
        .card_rsp_valid (card_rsp_valid),
        .card_rsp_byte  (card_rsp_byte),
        .card_rsp_done  (card_rsp_done),
        .irq            (irq)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // behavioural reference model
    int          m_state;
    int          m_cnt;
    logic [31:0] m_arg;
    logic [12:0] m_ctrl;
    logic [11:0] m_stat;
    logic [2:0]  m_mask;
    logic [7:0]  m_resp [16];
    bit          m_want, m_long;

    always @(posedge clk) begin
        int s;
        bit ok;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_arg = '0; m_ctrl = '0; m_stat = '0; m_mask = '0;
            m_want = 0; m_long = 0;
            foreach (m_resp[i]) m_resp[i] = 8'h00;
        end else begin
            s = m_state;
            if (reg_wr && reg_addr == 3'd2) m_stat = m_stat & ~(reg_wdata[11:0] & 12'hE00);
            if (s == 1) begin
                m_stat[11] = 1'b1;
                m_state = m_want ? 2 : 0;
                m_cnt = 0;
            end else if (s == 2) begin
                if (card_rsp_valid && m_cnt < 16) begin
                    m_resp[m_cnt] = card_rsp_byte;
                    m_cnt++;
                end
                if (card_rsp_done) begin
                    ok = m_long ? (m_cnt >= 16) : (m_cnt >= 4);
                    if (ok) m_stat[9] = 1'b1;
                    else begin
                        m_stat[10] = 1'b1;
                        foreach (m_resp[i]) m_resp[i] = 8'h00;
                    end
                    m_state = 0;
                end
            end
            if (reg_wr && s == 0 && reg_addr == 3'd0) m_arg = reg_wdata;
            if (reg_wr && s == 0 && reg_addr == 3'd1) begin
                m_ctrl = reg_wdata[12:0];
                if (reg_wdata[8]) begin
                    m_stat = {m_stat[11:9], 3'b000, reg_wdata[5:0]};
                    foreach (m_resp[i]) m_resp[i] = 8'h00;
                    m_want = reg_wdata[9];
                    m_long = reg_wdata[10];
                    m_state = 1;
                end
            end
            if (reg_wr && reg_addr == 3'd3) m_mask = reg_wdata[2:0];
        end
    end

    function automatic logic [31:0] exp_rdata(logic [2:0] a);
        case (a)
            3'd0: return m_arg;
            3'd1: return {19'b0, m_ctrl};
            3'd2: return {20'b0, m_stat};
            3'd3: return {29'b0, m_mask};
            default: begin
                int w = int'(a) - 4;
                return {m_resp[4*w], m_resp[4*w+1], m_resp[4*w+2], m_resp[4*w+3]};
            end
        endcase
    endfunction

    function automatic logic exp_irq();
        return (m_stat[11] & m_mask[0]) | (m_stat[9] & m_mask[1]) | (m_stat[10] & m_mask[2]);
    endfunction

    // every-cycle comparison, 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check("R2 R10 command strobe", 32'(card_cmd_valid), 32'(m_state == 1));
            if (m_state == 1) begin
                check("R2 command index", 32'(card_cmd_index), 32'(m_ctrl[5:0]));
                check("R2 command argument", card_cmd_arg, m_arg);
            end
            check("R9 interrupt level", 32'(irq), 32'(exp_irq()));
            check("R12 read-back", reg_rdata, exp_rdata(reg_addr));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic feed(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            card_rsp_valid = 1'b1;
            card_rsp_byte  = base + 8'(i);
        end
        @(negedge clk);
        card_rsp_valid = 1'b0;
        card_rsp_done  = 1'b1;
        @(negedge clk);
        card_rsp_done  = 1'b0;
    endtask

    task automatic summary();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        card_rsp_valid = 1'b0; card_rsp_byte = '0; card_rsp_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1 reset register");
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 strobe after reset", 32'(card_cmd_valid), 32'h0);

        // R2/R5/R6 short answer with 6 bytes, upper control bits dropped
        wr(3'd3, 32'h7);
        rd(3'd3, 32'h7, "R12 mask read-back");
        wr(3'd0, 32'h12345678);
        wr(3'd1, 32'hFFFF_E311);
        #1;
        check("R2 strobe after start", 32'(card_cmd_valid), 32'h1);
        check("R2 index", 32'(card_cmd_index), 32'h11);
        check("R2 argument", card_cmd_arg, 32'h12345678);
        feed(6, 8'hA1);
        rd(3'd1, 32'h0000_0311, "R2 control keeps 13 bits");
        rd(3'd4, 32'hA1A2A3A4, "R5 word 0 order");
        rd(3'd5, 32'hA5A60000, "R5 word 1 partial");
        rd(3'd2, 32'h0000_0A11, "R3 R6 status after short answer");
        check("R9 irq with all enabled", 32'(irq), 32'h1);

        // R8 write-one-to-clear
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, 32'h0000_0011, "R8 events cleared, index kept");
        check("R9 irq after clear", 32'(irq), 32'h0);

        // R6 short timeout with 3 bytes
        wr(3'd3, 32'h1);
        wr(3'd1, 32'h305);
        feed(3, 8'h10);
        rd(3'd2, 32'h0000_0C05, "R6 short timeout");
        rd(3'd4, 32'h0, "R6 words wiped on timeout");
        check("R9 irq from sent only", 32'(irq), 32'h1);
        wr(3'd2, 32'h800);
        rd(3'd2, 32'h0000_0405, "R8 partial clear");
        check("R9 timeout not enabled", 32'(irq), 32'h0);
        wr(3'd3, 32'h4);
        check("R9 timeout enabled", 32'(irq), 32'h1);
        wr(3'd2, 32'hE00);

        // R6 boundary: exactly 4 bytes
        wr(3'd1, 32'h306);
        feed(4, 8'h55);
        rd(3'd4, 32'h55565758, "R6 four bytes enough");
        rd(3'd2, 32'h0000_0A06, "R6 finish flag");
        wr(3'd2, 32'hE00);

        // R7/R5 long answer, 17 bytes (last dropped)
        wr(3'd1, 32'h702);
        feed(17, 8'h00);
        rd(3'd4, 32'h00010203, "R5 R7 word 0");
        rd(3'd5, 32'h04050607, "R5 R7 word 1");
        rd(3'd6, 32'h08090A0B, "R5 R7 word 2");
        rd(3'd7, 32'h0C0D0E0F, "R5 word 3, extra byte dropped");
        rd(3'd2, 32'h0000_0A02, "R7 long finish");
        wr(3'd2, 32'hE00);

        // R7 long timeout, 15 bytes
        wr(3'd1, 32'h703);
        feed(15, 8'h40);
        rd(3'd2, 32'h0000_0C03, "R7 long timeout");
        rd(3'd7, 32'h0, "R7 words wiped");
        wr(3'd2, 32'hE00);

        // R4/R11 no answer expected, strobes afterwards ignored
        wr(3'd1, 32'h109);
        feed(2, 8'h77);
        rd(3'd2, 32'h0000_0809, "R4 R11 no answer status");
        rd(3'd4, 32'h0, "R4 R11 words untouched");
        wr(3'd2, 32'hE00);

        // R10 writes while in flight
        wr(3'd0, 32'hCAFEF00D);
        wr(3'd1, 32'h314);
        @(negedge clk);
        wr(3'd0, 32'hDEAD0000);
        wr(3'd1, 32'h12A);
        rd(3'd0, 32'hCAFEF00D, "R10 argument held");
        rd(3'd1, 32'h0000_0314, "R10 control held");
        feed(4, 8'h01);
        rd(3'd2, 32'h0000_0A14, "R10 first command completes");
        wr(3'd2, 32'hE00);

        // R8 event beats a clear in the same cycle
        wr(3'd1, 32'h318);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            card_rsp_valid = 1'b1;
            card_rsp_byte  = 8'(i);
        end
        @(negedge clk);
        card_rsp_valid = 1'b0;
        card_rsp_done  = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h200;
        @(negedge clk);
        card_rsp_done = 1'b0;
        reg_wr = 1'b0;
        rd(3'd2, 32'h0000_0A18, "R8 same-cycle event kept");

        repeat (2) @(negedge clk);
        summary();
    end

endmodule